// File: doc/BRIEF.md
# Configuration Register Access Checker

This block sits in front of a device's small configuration register file and decides, request by request, whether an access is allowed before it reaches storage. Each request names a dword within the device's 4 KB configuration space, carries a four-bit lane enable and says which path it came in on: the port-based configuration mechanism or a memory-mapped transaction. Legal writes update only the enabled byte lanes, using little-endian lane order. Legal reads return the enabled lanes.

An illegal access never touches storage. It raises a one-cycle error flag on its response. An illegal read also returns all ones, so software probing a forbidden location sees the usual "nothing here" value.

The legality rules depend on three things: where the dword sits, which path the access used, and whether the dword is the one holding the configuration address register. Every request gets exactly one response, one cycle later.

Top module: `cfg_acc_checker`

## Requirements
- R1: In the low region (dwords 0 to 63, byte offsets 0 to 255), apart from the configuration address dword, lane enables 0001, 0010, 0100, 1000 (byte), 0011, 1100 (aligned word) and 1111 (dword) are legal on either path. Every other pattern, including 0000 and 0110, is illegal.
- R2: The configuration address dword (default dword 6) is legal only with lane enable 1111, on either path.
- R3: Any access on the port path (req_mmio = 0) to dwords 64 to 1023 is illegal.
- R4: A memory-mapped access (req_mmio = 1) to dwords 64 to 1023 is legal only with lane enable 1111.
- R5: A legal write updates only the lanes whose enable bit is set. Lane i holds bits 8i+7:8i, which is byte offset 4*dword+i, so the lowest address holds the least significant byte.
- R6: An illegal write leaves every register unchanged and gives a response with rsp_err = 1 for exactly that one response.
- R7: An illegal read returns FFFF_FFFFh with rsp_err = 1.
- R8: Each request accepted at a clock edge produces rsp_valid = 1 one cycle later. A legal read returns the enabled lanes with disabled lanes zero. A write response carries data zero.
- R9: After reset every register reads zero, and rsp_valid and rsp_err are low.
- R10: A legal access to an unimplemented dword reads zero, has no effect when written, and does not raise rsp_err. Implemented dwords are 0 to 7 and 64 to 67.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mmio | input | 1 | 1 = memory-mapped path, 0 = port configuration path |
| req_dw | input | 10 | Dword index into the 4 KB space (byte offset / 4) |
| req_be | input | 4 | Lane enables, bit i = byte offset 4*req_dw+i |
| req_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Response belongs to an illegal access |
| rsp_rdata | output | 32 | Read data, or all ones for an illegal read |

## Verification
The hardest case to observe from the ports is an illegal write that must leave storage untouched. The error flag alone does not show whether some lanes were written anyway. The stimulus first loads a known pattern with a legal write. It then issues the forbidden write, such as a misaligned word, a partial write to the configuration address dword, or a port-path write to the extended region. Finally it reads the same dword back with a full legal read and compares every lane. The same sequence is used on lane-masked writes, to confirm that untouched lanes survive a legal partial write.

// File: rtl/cfg_acc_pkg.sv
package cfg_acc_pkg;

    localparam int SPACE_BYTES = 4096;
    localparam int LOW_BYTES   = 256;
    localparam int LANES       = 4;
    localparam int DATA_W      = LANES * 8;
    localparam int DW_W        = $clog2(SPACE_BYTES / LANES);
    localparam int LOW_LIMIT   = LOW_BYTES / LANES;

    typedef logic [DW_W-1:0]   dwaddr_t;
    typedef logic [LANES-1:0]  lanes_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        AREA_LOW  = 2'd0,
        AREA_CFGA = 2'd1,
        AREA_EXT  = 2'd2
    } area_e;

    typedef struct packed {
        area_e area;
        logic  legal;
        logic  hit;
    } verdict_t;

    // Natural byte, aligned word or full dword patterns.
    function automatic logic natural_lanes(input lanes_t be);
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b0011, 4'b1100, 4'b1111: natural_lanes = 1'b1;
            default:                   natural_lanes = 1'b0;
        endcase
    endfunction

    function automatic word_t lane_mask(input lanes_t be);
        word_t m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_acc_decode.sv
module cfg_acc_decode
    import cfg_acc_pkg::*;
#(
    parameter int LOW_DW    = 8,
    parameter int EXT_DW    = 4,
    parameter int CFGADR_DW = 6,
    parameter int IDX_W     = $clog2(LOW_DW + EXT_DW)
) (
    input  logic       mmio,
    input  dwaddr_t    dw,
    input  lanes_t     be,
    output verdict_t   verdict,
    output logic [IDX_W-1:0] idx
);
    localparam dwaddr_t EXT_BASE = dwaddr_t'(LOW_LIMIT);
    localparam dwaddr_t CFGA     = dwaddr_t'(CFGADR_DW);
    localparam dwaddr_t LOW_TOP  = dwaddr_t'(LOW_DW);
    localparam dwaddr_t EXT_TOP  = dwaddr_t'(EXT_DW);

    dwaddr_t rel;

    always_comb begin
        rel         = dw - EXT_BASE;
        verdict     = '0;
        idx         = '0;
        if (dw >= EXT_BASE) begin
            verdict.area  = AREA_EXT;
            verdict.legal = mmio && (be == 4'b1111);
            verdict.hit   = rel < EXT_TOP;
            idx           = IDX_W'(LOW_DW) + IDX_W'(rel);
        end else if (dw == CFGA) begin
            verdict.area  = AREA_CFGA;
            verdict.legal = (be == 4'b1111);
            verdict.hit   = dw < LOW_TOP;
            idx           = IDX_W'(dw);
        end else begin
            verdict.area  = AREA_LOW;
            verdict.legal = natural_lanes(be);
            verdict.hit   = dw < LOW_TOP;
            idx           = IDX_W'(dw);
        end
    end

endmodule

// File: rtl/cfg_acc_regfile.sv
module cfg_acc_regfile
    import cfg_acc_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  lanes_t           be,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t store [DEPTH];

    for (genvar d = 0; d < DEPTH; d++) begin : g_dw
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    store[d][l*8 +: 8] <= '0;
                end else if (we && idx == IDX_W'(d) && be[l]) begin
                    store[d][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (idx == IDX_W'(d)) rdata = store[d];
        end
    end

endmodule

// File: rtl/cfg_acc_checker.sv
module cfg_acc_checker
    import cfg_acc_pkg::*;
#(
    parameter int LOW_DW    = 8,
    parameter int EXT_DW    = 4,
    parameter int CFGADR_DW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_mmio,
    input  logic [9:0]  req_dw,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    localparam int DEPTH = LOW_DW + EXT_DW;
    localparam int IDX_W = $clog2(DEPTH);

    verdict_t         verdict;
    logic [IDX_W-1:0] idx;
    word_t            rd_word;
    logic             wr_en;

    cfg_acc_decode #(
        .LOW_DW(LOW_DW), .EXT_DW(EXT_DW), .CFGADR_DW(CFGADR_DW), .IDX_W(IDX_W)
    ) u_decode (
        .mmio(req_mmio), .dw(req_dw), .be(req_be),
        .verdict(verdict), .idx(idx)
    );

    assign wr_en = req_valid && req_write && verdict.legal && verdict.hit;

    cfg_acc_regfile #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .we(wr_en), .idx(idx),
        .be(req_be), .wdata(req_wdata), .rdata(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !verdict.legal;
            if (!req_valid || req_write)
                rsp_rdata <= '0;
            else if (!verdict.legal)
                rsp_rdata <= '1;
            else if (verdict.hit)
                rsp_rdata <= rd_word & lane_mask(req_be);
            else
                rsp_rdata <= '0;
        end
    end

endmodule

// File: rtl/cfg_acc_checker_sva.sv
module cfg_acc_checker_sva #(
    parameter int CFGADR_DW = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_mmio,
    input logic [9:0]  req_dw,
    input logic [3:0]  req_be,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata
);
    logic natural_be;
    assign natural_be = (req_be == 4'h1) || (req_be == 4'h2) || (req_be == 4'h4) ||
                        (req_be == 4'h8) || (req_be == 4'h3) || (req_be == 4'hC) ||
                        (req_be == 4'hF);

    a_r8_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_err);

    a_r1_natural_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dw < 10'd64 && req_dw != 10'(CFGADR_DW) && natural_be)
        |=> !rsp_err);

    a_r1_odd_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dw < 10'd64 && !natural_be) |=> rsp_err);

    a_r2_cfga_dword_only: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dw == 10'(CFGADR_DW) && req_be != 4'hF) |=> rsp_err);

    a_r3_port_ext_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_mmio && req_dw >= 10'd64) |=> rsp_err);

    a_r4_ext_partial_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mmio && req_dw >= 10'd64 && req_be != 4'hF) |=> rsp_err);

    a_r7_bad_read_ones: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (!rsp_err || rsp_rdata == 32'hFFFF_FFFF));

    a_r8_write_data_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> rsp_rdata == 32'h0);

endmodule

bind cfg_acc_checker cfg_acc_checker_sva #(.CFGADR_DW(CFGADR_DW)) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mmio(req_mmio), .req_dw(req_dw), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_cfg_acc_checker.sv
module sim_cfg_acc_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_mmio  = 1'b0;
    logic [9:0]  req_dw    = '0;
    logic [3:0]  req_be    = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_acc_checker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mmio(req_mmio), .req_dw(req_dw), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge; its response is read one edge later.
    task automatic access(input logic wr, input logic mm, input logic [9:0] dw,
                          input logic [3:0] be, input logic [31:0] wd,
                          output logic [31:0] rd, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mmio = mm;
        req_dw = dw; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd  = rsp_rdata;
        err = rsp_err;
        if (rsp_valid !== 1'b1) begin
            n_checks++; n_fail++;
            $display("FAIL R8 rsp_valid: actual %b expected 1", rsp_valid);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        check("R9", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check("R9", "rsp_err after reset",   {31'b0, rsp_err},   32'h0);
        access(1'b0, 1'b1, 10'd3, 4'hF, '0, d, e);
        check("R9", "dw3 reset value", d, 32'h0);
        access(1'b0, 1'b1, 10'd66, 4'hF, '0, d, e);
        check("R9", "dw66 reset value", d, 32'h0);
    endtask

    task automatic t_lanes;
        logic [31:0] d; logic e;
        access(1'b1, 1'b0, 10'd1, 4'hF, 32'h1122_3344, d, e);
        check("R8", "write response data", d, 32'h0);
        access(1'b1, 1'b0, 10'd1, 4'b0010, 32'hAABB_CCDD, d, e);
        check("R5", "lane1 write err", {31'b0, e}, 32'h0);
        access(1'b0, 1'b0, 10'd1, 4'hF, '0, d, e);
        check("R5", "lane1 only updated", d, 32'h1122_CC44);
        access(1'b0, 1'b1, 10'd1, 4'b0001, '0, d, e);
        check("R8", "byte0 read", d, 32'h0000_0044);
        access(1'b0, 1'b0, 10'd1, 4'b1100, '0, d, e);
        check("R8", "upper word read", d, 32'h1122_0000);
        check("R1", "upper word legal", {31'b0, e}, 32'h0);
    endtask

    task automatic t_alignment;
        logic [31:0] d; logic e;
        access(1'b1, 1'b1, 10'd2, 4'b0011, 32'hDEAD_BEEF, d, e);
        check("R1", "aligned word write", {31'b0, e}, 32'h0);
        access(1'b1, 1'b1, 10'd2, 4'b0110, 32'h5555_5555, d, e);
        check("R1", "misaligned word flagged", {31'b0, e}, 32'h1);
        access(1'b1, 1'b1, 10'd2, 4'b0000, 32'h6666_6666, d, e);
        check("R1", "empty enables flagged", {31'b0, e}, 32'h1);
        access(1'b0, 1'b1, 10'd2, 4'hF, '0, d, e);
        check("R6", "dw2 unchanged by bad writes", d, 32'h0000_BEEF);
        access(1'b0, 1'b1, 10'd2, 4'b1110, '0, d, e);
        check("R7", "three-lane read ones", d, 32'hFFFF_FFFF);
        check("R7", "three-lane read err", {31'b0, e}, 32'h1);
    endtask

    task automatic t_cfg_addr;
        logic [31:0] d; logic e;
        access(1'b1, 1'b0, 10'd6, 4'hF, 32'h8000_1234, d, e);
        check("R2", "cfg addr dword write", {31'b0, e}, 32'h0);
        access(1'b1, 1'b0, 10'd6, 4'b0001, 32'h0000_00FF, d, e);
        check("R2", "cfg addr byte write flagged", {31'b0, e}, 32'h1);
        access(1'b1, 1'b1, 10'd6, 4'b1100, 32'hFFFF_0000, d, e);
        check("R2", "cfg addr word write flagged", {31'b0, e}, 32'h1);
        access(1'b0, 1'b0, 10'd6, 4'b0011, '0, d, e);
        check("R2", "cfg addr word read ones", d, 32'hFFFF_FFFF);
        access(1'b0, 1'b1, 10'd6, 4'hF, '0, d, e);
        check("R6", "cfg addr unchanged", d, 32'h8000_1234);
    endtask

    task automatic t_ext;
        logic [31:0] d; logic e;
        access(1'b1, 1'b1, 10'd65, 4'hF, 32'hCAFE_F00D, d, e);
        check("R4", "ext dword write", {31'b0, e}, 32'h0);
        access(1'b1, 1'b0, 10'd65, 4'hF, 32'h0BAD_0BAD, d, e);
        check("R3", "port ext write flagged", {31'b0, e}, 32'h1);
        access(1'b0, 1'b0, 10'd65, 4'hF, '0, d, e);
        check("R3", "port ext read ones", d, 32'hFFFF_FFFF);
        access(1'b1, 1'b1, 10'd65, 4'b0011, 32'h0000_1111, d, e);
        check("R4", "ext word write flagged", {31'b0, e}, 32'h1);
        access(1'b0, 1'b1, 10'd65, 4'b0001, '0, d, e);
        check("R4", "ext byte read ones", d, 32'hFFFF_FFFF);
        access(1'b0, 1'b1, 10'd65, 4'hF, '0, d, e);
        check("R6", "ext dword unchanged", d, 32'hCAFE_F00D);
    endtask

    task automatic t_unimpl;
        logic [31:0] d; logic e;
        access(1'b1, 1'b0, 10'd20, 4'hF, 32'h1357_9BDF, d, e);
        check("R10", "unimpl low write no err", {31'b0, e}, 32'h0);
        access(1'b0, 1'b0, 10'd20, 4'hF, '0, d, e);
        check("R10", "unimpl low reads zero", d, 32'h0);
        access(1'b1, 1'b1, 10'd200, 4'hF, 32'h2468_ACE0, d, e);
        access(1'b0, 1'b1, 10'd200, 4'hF, '0, d, e);
        check("R10", "unimpl ext reads zero", d, 32'h0);
        check("R10", "unimpl ext no err", {31'b0, e}, 32'h0);
        access(1'b0, 1'b1, 10'd1, 4'hF, '0, d, e);
        check("R10", "dw1 intact after unimpl writes", d, 32'h1122_CC44);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_alignment();
        t_cfg_addr();
        t_ext();
        t_unimpl();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule